// File: doc/BRIEF.md
# Sequential Radix-2 Booth Multiplier

This block multiplies two signed two's-complement operands of `N` bits each and returns a signed `2N`-bit product. It works over several cycles and has a single adder/subtractor. The operand pair enters through a valid/ready handshake. Once accepted, the block examines the lowest multiplier bit together with a trailing history bit. From that pair it adds the multiplicand into a running accumulator, subtracts it, or leaves the accumulator alone. It then shifts the whole accumulator, multiplier and history chain one place to the right, keeping the sign. After `N` such steps the product sits in place across the upper accumulator bits and the multiplier register, and a one-cycle `done` pulse marks it.

The input has simple back-pressure. `in_ready` is high only while the block is idle. A transfer happens on any rising edge where both `in_valid` and `in_ready` are high. While a multiplication is running, or while `done` is high, `in_ready` stays low and the block ignores `in_valid`. The operands are copied at the accepting edge, so the source may change them right after. The result side has no back-pressure. `product` keeps its value from the `done` cycle until the next accepted transfer.

Top module: `booth_mul_seq`

## Requirements
- R1: After reset `in_ready` is 1, `done` is 0 and `product` is all zeros.
- R2: A transfer is accepted on a rising edge with `in_valid` and `in_ready` both 1. `in_ready` is 0 from the next cycle until the cycle after the `done` pulse.
- R3: Any `in_valid`, `multiplicand` or `multiplier` activity while `in_ready` is 0 has no effect on the running result or on its timing.
- R4: `done` is high for exactly one cycle. It rises N+1 rising edges after the accepting edge (5 edges for N = 4).
- R5: While `done` is high, `product` equals the signed product of the accepted operands as a 2N-bit two's-complement value, for every pair of signed N-bit operands.
- R6: For N = 4, multiplicand 0111 (+7) times multiplier 1011 (-5) gives `product` = 1101_1101 (-35).
- R7: The most negative operand gives correct results. For N = 4: 1000 × 1000 = 0100_0000 (+64), 1000 × 0001 = 1111_1000 (-8), and 0111 × 1000 = 1100_1000 (-56).
- R8: `product` keeps its value from the `done` cycle until the next accepted transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand pair is offered |
| in_ready | output | 1 | Block is idle and will take an operand pair |
| multiplicand | input | N | Signed multiplicand |
| multiplier | input | N | Signed multiplier |
| done | output | 1 | One-cycle pulse: product is final |
| product | output | 2N | Signed product, held until the next transfer |

## Verification
Two things can overlap in one cycle: a new operand pair being offered, and the end of the current multiplication (the `done` cycle). The bench holds `in_valid` high with different operands through the whole run, including the `done` cycle. In that cycle it checks that `in_ready` is 0 and that `product` still carries the first result. It then checks that the new pair is taken on the following idle edge and produces its own correct product with the normal latency. The exhaustive sweep and the extreme-value cases judge arithmetic correctness against a signed multiply computed in the bench.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_STEP = 2'd2,
    ST_DONE = 2'd3
  } booth_state_t;

  typedef enum logic [1:0] {
    OP_SHIFT = 2'd0,
    OP_ADD   = 2'd1,
    OP_SUB   = 2'd2
  } booth_op_t;

  // Radix-2 recoding of the (lsb, history) pair
  function automatic booth_op_t recode_pair(input logic lsb, input logic hist);
    case ({lsb, hist})
      2'b10:   return OP_SUB;
      2'b01:   return OP_ADD;
      default: return OP_SHIFT;
    endcase
  endfunction

endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic q_lsb,
  input  logic q_hist,
  output logic use_sum,
  output logic subtract
);
  booth_op_t op;

  always_comb begin
    op       = recode_pair(q_lsb, q_hist);
    use_sum  = (op != OP_SHIFT);
    subtract = (op == OP_SUB);
  end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub #(
  parameter int W = 5
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         subtract,
  output logic [W-1:0] sum
);
  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = b ^ {W{subtract}};
    sum   = a + b_eff + W'(subtract);
  end
endmodule

// File: rtl/booth_shift.sv
module booth_shift #(
  parameter int AW = 5,
  parameter int QW = 4
) (
  input  logic [AW-1:0] a_in,
  input  logic [QW-1:0] q_in,
  output logic [AW-1:0] a_out,
  output logic [QW-1:0] q_out,
  output logic          hist_out
);
  always_comb begin
    a_out    = {a_in[AW-1], a_in[AW-1:1]};
    q_out    = {a_in[0], q_in[QW-1:1]};
    hist_out = q_in[0];
  end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic accept,
  output logic step_en,
  output logic done
);
  localparam int CW = $clog2(N + 1);

  booth_state_t state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    in_ready = (state_q == ST_IDLE);
    accept   = in_ready && in_valid;
    step_en  = (state_q == ST_STEP);
    done     = (state_q == ST_DONE);
    state_d  = state_q;
    cnt_d    = cnt_q;
    case (state_q)
      ST_IDLE: if (in_valid) state_d = ST_LOAD;
      ST_LOAD: begin
        cnt_d   = CW'(N);
        state_d = ST_STEP;
      end
      ST_STEP: begin
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == CW'(1)) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/booth_mul_seq.sv
module booth_mul_seq #(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [N-1:0]   multiplicand,
  input  logic [N-1:0]   multiplier,
  output logic           done,
  output logic [2*N-1:0] product
);
  // accumulator carries one guard bit so that subtracting the most
  // negative multiplicand cannot wrap
  localparam int AW = N + 1;

  logic          accept, step_en;
  logic [AW-1:0] acc_q;
  logic [N-1:0]  mcand_q, mplier_q;
  logic          hist_q;

  logic          use_sum, subtract;
  logic [AW-1:0] mcand_ext, sum, acc_pre, acc_nxt;
  logic [N-1:0]  mplier_nxt;
  logic          hist_nxt;

  booth_ctrl #(.N(N)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .accept   (accept),
    .step_en  (step_en),
    .done     (done)
  );

  booth_recode u_recode (
    .q_lsb    (mplier_q[0]),
    .q_hist   (hist_q),
    .use_sum  (use_sum),
    .subtract (subtract)
  );

  assign mcand_ext = {mcand_q[N-1], mcand_q};

  booth_addsub #(.W(AW)) u_addsub (
    .a        (acc_q),
    .b        (mcand_ext),
    .subtract (subtract),
    .sum      (sum)
  );

  assign acc_pre = use_sum ? sum : acc_q;

  booth_shift #(.AW(AW), .QW(N)) u_shift (
    .a_in     (acc_pre),
    .q_in     (mplier_q),
    .a_out    (acc_nxt),
    .q_out    (mplier_nxt),
    .hist_out (hist_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      hist_q   <= 1'b0;
    end else if (accept) begin
      acc_q    <= '0;
      mcand_q  <= multiplicand;
      mplier_q <= multiplier;
      hist_q   <= 1'b0;
    end else if (step_en) begin
      acc_q    <= acc_nxt;
      mplier_q <= mplier_nxt;
      hist_q   <= hist_nxt;
    end
  end

  assign product = {acc_q[N-1:0], mplier_q};
endmodule

// File: rtl/booth_mul_seq_chk.sv
module booth_mul_seq_chk #(
  parameter int N = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           done,
  input logic [2*N-1:0] product
);
  localparam int SW = $clog2(N + 3) + 1;
  localparam logic [SW-1:0] SMAX = {SW{1'b1}};

  logic [SW-1:0] since_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_acc <= '0;
    else if (in_valid && in_ready) since_acc <= '0;
    else if (since_acc != SMAX) since_acc <= since_acc + 1'b1;
  end

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r2_not_ready_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

  a_r3_stay_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !done) |=> !in_ready);

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r4_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (since_acc == SW'(N + 1)));

  a_r8_hold_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(product));

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> $stable(product));
endmodule

bind booth_mul_seq booth_mul_seq_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .done     (done),
  .product  (product)
);

// File: tb/booth_mul_seq_tb.sv
module booth_mul_seq_tb;
  localparam int N = 4;
  localparam int PW = 2 * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [N-1:0]  multiplicand = '0;
  logic [N-1:0]  multiplier = '0;
  logic          done;
  logic [PW-1:0] product;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;  // 4 ns period

  booth_mul_seq #(.N(N)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .done         (done),
    .product      (product)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
    return PW'(signed'(a) * signed'(b));
  endfunction

  // offer one pair, wait for done; returns product and latency in edges
  task automatic run(input logic [N-1:0] a, input logic [N-1:0] b,
                     output logic [PW-1:0] res, output int lat, output bit timed_out);
    @(negedge clk);
    in_valid = 1'b1; multiplicand = a; multiplier = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; multiplicand = ~a; multiplier = ~b;
    lat = 0; timed_out = 1'b0;
    while (!done) begin
      @(negedge clk);
      lat++;
      if (lat > 50) begin timed_out = 1'b1; break; end
    end
    res = product;
  endtask

  task automatic run_check(input logic [N-1:0] a, input logic [N-1:0] b, input string req);
    logic [PW-1:0] res; int lat; bit to;
    run(a, b, res, lat, to);
    check(!to, {req, " timeout"}, lat, N + 1);
    check(res == ref_mul(a, b), req, res, ref_mul(a, b));
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    check(done == 1'b0, "R1 done", done, 0);
    check(product == '0, "R1 product", product, 0);
  endtask

  task automatic t_example;
    logic [PW-1:0] res; int lat; bit to;
    run(4'b0111, 4'b1011, res, lat, to);
    check(res == 8'b1101_1101, "R6 7x-5", res, 8'hDD);
    check(lat == N + 1, "R4 latency", lat, N + 1);
    @(negedge clk);
    check(done == 1'b0, "R4 single pulse", done, 0);
    check(in_ready == 1'b1, "R2 ready after done", in_ready, 1);
  endtask

  task automatic t_extremes;
    logic [PW-1:0] res; int lat; bit to;
    run(4'b1000, 4'b1000, res, lat, to);
    check(res == 8'b0100_0000, "R7 -8x-8", res, 8'h40);
    run(4'b1000, 4'b0001, res, lat, to);
    check(res == 8'b1111_1000, "R7 -8x1", res, 8'hF8);
    run(4'b0111, 4'b1000, res, lat, to);
    check(res == 8'b1100_1000, "R7 7x-8", res, 8'hC8);
  endtask

  task automatic t_hold;
    logic [PW-1:0] res; int lat; bit to;
    run(4'b0011, 4'b1110, res, lat, to);
    for (int i = 0; i < 6; i++) begin
      multiplicand = 4'(i); multiplier = 4'(i + 3);
      @(negedge clk);
    end
    check(product == ref_mul(4'b0011, 4'b1110), "R8 hold idle", product, ref_mul(4'b0011, 4'b1110));
  endtask

  // new operands offered during the run and through the done cycle
  task automatic t_busy_offer;
    logic [PW-1:0] exp1, exp2;
    int lat; bit seen;
    exp1 = ref_mul(4'b0101, 4'b1101);
    exp2 = ref_mul(4'b1010, 4'b0110);
    @(negedge clk);
    in_valid = 1'b1; multiplicand = 4'b0101; multiplier = 4'b1101;
    @(posedge clk);
    @(negedge clk);
    multiplicand = 4'b1010; multiplier = 4'b0110;  // keep offering
    check(in_ready == 1'b0, "R2 busy after accept", in_ready, 0);
    lat = 0; seen = 1'b0;
    while (!done && lat < 50) begin
      check(in_ready == 1'b0, "R3 not ready while busy", in_ready, 0);
      @(negedge clk);
      lat++;
    end
    check(lat == N + 1, "R3 latency unchanged", lat, N + 1);
    check(in_ready == 1'b0, "R3 not ready in done", in_ready, 0);
    check(product == exp1, "R3 result unaffected", product, exp1);
    @(negedge clk);
    check(in_ready == 1'b1 && product == exp1, "R8 held in idle cycle", product, exp1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    seen = done;
    check(seen, "R2 second transfer done", seen, 1);
    check(product == exp2, "R2 second transfer product", product, exp2);
  endtask

  task automatic t_exhaustive;
    int errs;
    errs = 0;
    for (int a = 0; a < (1 << N); a++) begin
      for (int b = 0; b < (1 << N); b++) begin
        logic [PW-1:0] res; int lat; bit to;
        run(N'(a), N'(b), res, lat, to);
        if (res !== ref_mul(N'(a), N'(b)) || lat != N + 1) begin
          errs++;
          check(1'b0, "R5 pair", res, ref_mul(N'(a), N'(b)));
        end
      end
    end
    check(errs == 0, "R5 exhaustive", errs, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_example();
    t_extremes();
    run_check(4'b0000, 4'b1111, "R5 zero");
    t_hold();
    t_busy_offer();
    t_exhaustive();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule